// File: doc/BRIEF.md
# Burst DMA Request Engine

This block is the device side of a request/acknowledge handshake between a local buffer memory and an external system DMA controller. Software supplies a start address, a direction, a burst size in bytes, a total length in bytes, a bus width (16 or 32 bits) and the active levels of the request and acknowledge pins. A start strobe sets the enable bit. The engine then raises its request line, one burst at a time.

Each bus cycle in which request and acknowledge are both active is one beat. On each beat the engine issues a local memory strobe with a byte-lane mask and advances the local address by the bus width. Lengths that are not a multiple of the bus width are padded on the bus. On writes into local memory, the lane mask limits the change to the requested bytes. When the last byte has moved, the request drops and a sticky end-of-transfer flag is set. That flag can drive an interrupt.

Top module: `burst_dreq_engine`

## Requirements
- R1: After reset the request pin is at its inactive level. `busy`, `eot_flag` and `irq` are all 0.
- R2: A `cfg_start` pulse while idle with a nonzero length makes the request active and `busy` 1 from the next cycle on. A `cfg_start` pulse with a zero length is ignored.
- R3: A beat is a cycle in which request and acknowledge are both active. Each beat advances `mem_addr` by 4 in 32-bit mode (`cfg_wide`=1) or by 2 in 16-bit mode. The first beat uses the start address with its low 2 bits (32-bit mode) or low bit (16-bit mode) forced to zero.
- R4: The burst size is counted in bytes whatever the bus width. A burst has ceil(burst/width) beats, with a minimum of 1. Between bursts the request goes inactive for exactly one cycle and then returns.
- R5: The total number of beats is ceil(length/width). The last burst is cut short by the bytes that remain.
- R6: On a write beat, `mem_be` bit i stands for byte lane i, and lanes 0 to n-1 are set, where n = min(remaining bytes, width). On a read beat `mem_be` is 4'hF in 32-bit mode and 4'h3 in 16-bit mode.
- R7: `mem_we` pulses on beats when `cfg_write`=1 (the system writes into local memory). `mem_re` pulses on beats when `cfg_write`=0. They never pulse outside a beat and never both at once.
- R8: In the cycle after the last beat, the request is inactive, `busy` is 0 and `eot_flag` is 1.
- R9: `irq` = `eot_flag` AND `cfg_eot_ie`. `eot_flag` holds until a cycle with `eot_clr`=1 clears it.
- R10: `cfg_req_hi`=1 makes the request pin active-high; 0 makes it active-low. `cfg_ack_hi` does the same for the acknowledge pin.
- R11: A `cfg_start` pulse while `busy` is ignored. The running transfer keeps its address, length and beat count.
- R12: An active acknowledge while the request is inactive (idle or between bursts) produces no beat and moves no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Sets the enable bit (one-cycle pulse) |
| cfg_addr | input | ADDR_W | Local start address in bytes |
| cfg_write | input | 1 | 1: system writes local memory; 0: system reads it |
| cfg_burst | input | BURST_W | Burst size in bytes |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_wide | input | 1 | 1: 32-bit bus; 0: 16-bit bus |
| cfg_req_hi | input | 1 | Request pin active level |
| cfg_ack_hi | input | 1 | Acknowledge pin active level |
| cfg_eot_ie | input | 1 | End-of-transfer interrupt enable |
| eot_clr | input | 1 | Clears `eot_flag` |
| dma_ack | input | 1 | Acknowledge pin from the system DMA |
| dma_req | output | 1 | Request pin to the system DMA |
| busy | output | 1 | Enable bit readback; high while a transfer runs |
| mem_addr | output | ADDR_W | Local memory byte address of the current beat |
| mem_we | output | 1 | Local memory write strobe |
| mem_re | output | 1 | Local memory read strobe |
| mem_be | output | 4 | Byte-lane enables |
| eot_flag | output | 1 | Sticky end-of-transfer status |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
The assertions check on every cycle the following properties:
- strobes appear only while the request is active, and read and write strobes never coincide;
- the address advances by the bus width after each beat that is not the last;
- a burst that ends early is followed by a request-free cycle;
- the counters freeze while no beat is taken;
- completion clears `busy` and sets the flag.

Only the bench scenarios can show the following:
- the beat and burst counts for a given length and burst size;
- the partial lane mask on the final write beat;
- start-address alignment;
- the inverted pin levels;
- that a start strobe during a transfer leaves its outcome unchanged.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } dreq_state_e;

  localparam int unsigned LANES = 4;

  // bytes moved per bus cycle
  function automatic logic [2:0] beat_bytes(input logic wide);
    return wide ? 3'd4 : 3'd2;
  endfunction

  // bytes of real data carried by the next beat
  function automatic int unsigned take_bytes(input int unsigned rem, input logic wide);
    int unsigned bw;
    bw = wide ? 4 : 2;
    return (rem < bw) ? rem : bw;
  endfunction

  // lanes 0..n-1 enabled
  function automatic logic [LANES-1:0] lane_mask(input int unsigned n);
    case (n)
      0: return 4'b0000;
      1: return 4'b0001;
      2: return 4'b0011;
      3: return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/xfer_cnt.sv
module xfer_cnt
  import dreq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 16,
  parameter int BURST_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic [LEN_W-1:0]   ld_len,
  input  logic [BURST_W-1:0] ld_burst,
  input  logic               ld_wide,
  input  logic               step,
  output logic [ADDR_W-1:0]  addr,
  output logic [LEN_W-1:0]   rem,
  output logic               wide,
  output logic               last_beat,
  output logic               burst_end
);

  logic [ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]   rem_q;
  logic [BURST_W-1:0] burst_cfg_q;
  logic [BURST_W-1:0] burst_left_q;
  logic               wide_q;
  logic [2:0]         bw;
  logic [ADDR_W-1:0]  align_mask;
  int unsigned        take;

  always_comb begin
    bw         = beat_bytes(wide_q);
    take       = take_bytes(32'(rem_q), wide_q);
    last_beat  = 32'(rem_q) <= 32'(bw);
    burst_end  = 32'(burst_left_q) <= 32'(bw);
    align_mask = ld_wide ? ~ADDR_W'(3) : ~ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q       <= '0;
      rem_q        <= '0;
      burst_cfg_q  <= '0;
      burst_left_q <= '0;
      wide_q       <= 1'b0;
    end else if (load) begin
      addr_q       <= ld_addr & align_mask;
      rem_q        <= ld_len;
      burst_cfg_q  <= ld_burst;
      burst_left_q <= ld_burst;
      wide_q       <= ld_wide;
    end else if (step) begin
      addr_q <= addr_q + ADDR_W'(bw);
      rem_q  <= rem_q - LEN_W'(take);
      if (burst_end) burst_left_q <= burst_cfg_q;
      else           burst_left_q <= burst_left_q - BURST_W'(bw);
    end
  end

  assign addr = addr_q;
  assign rem  = rem_q;
  assign wide = wide_q;

endmodule

// File: rtl/dreq_ctrl.sv
module dreq_ctrl
  import dreq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic len_nz,
  input  logic ack,
  input  logic last_beat,
  input  logic burst_end,
  output logic load,
  output logic step,
  output logic done,
  output logic req,
  output logic busy
);

  dreq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start && len_nz) begin
          load    = 1'b1;
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (ack) begin
          step = 1'b1;
          if (last_beat) begin
            done    = 1'b1;
            state_d = ST_IDLE;
          end else if (burst_end) begin
            state_d = ST_GAP;
          end
        end
      end
      ST_GAP:  state_d = ST_REQ;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req  = (state_q == ST_REQ);
  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/lane_gen.sv
module lane_gen
  import dreq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             step,
  input  logic             write,
  input  logic             wide,
  input  logic [LEN_W-1:0] rem,
  output logic             mem_we,
  output logic             mem_re,
  output logic [LANES-1:0] mem_be
);

  logic [LANES-1:0] part_mask;
  logic [LANES-1:0] full_mask;

  always_comb begin
    part_mask = lane_mask(take_bytes(32'(rem), wide));
    full_mask = lane_mask(32'(beat_bytes(wide)));
    mem_we    = step && write;
    mem_re    = step && !write;
    if (!step)      mem_be = '0;
    else if (write) mem_be = part_mask;
    else            mem_be = full_mask;
  end

endmodule

// File: rtl/burst_dreq_engine.sv
module burst_dreq_engine
  import dreq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 16,
  parameter int BURST_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_start,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic               cfg_write,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               cfg_wide,
  input  logic               cfg_req_hi,
  input  logic               cfg_ack_hi,
  input  logic               cfg_eot_ie,
  input  logic               eot_clr,
  input  logic               dma_ack,
  output logic               dma_req,
  output logic               busy,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_we,
  output logic               mem_re,
  output logic [3:0]         mem_be,
  output logic               eot_flag,
  output logic               irq
);

  // internal events, named for the checker
  logic             load, step, done, req_int, ack_int;
  logic             last_beat, burst_end, wide;
  logic             write_q;
  logic [LEN_W-1:0] rem;

  assign ack_int = cfg_ack_hi ? dma_ack : ~dma_ack;
  assign dma_req = cfg_req_hi ? req_int : ~req_int;

  dreq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cfg_start),
    .len_nz    (|cfg_len),
    .ack       (ack_int),
    .last_beat (last_beat),
    .burst_end (burst_end),
    .load      (load),
    .step      (step),
    .done      (done),
    .req       (req_int),
    .busy      (busy)
  );

  xfer_cnt #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_W(BURST_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .ld_addr   (cfg_addr),
    .ld_len    (cfg_len),
    .ld_burst  (cfg_burst),
    .ld_wide   (cfg_wide),
    .step      (step),
    .addr      (mem_addr),
    .rem       (rem),
    .wide      (wide),
    .last_beat (last_beat),
    .burst_end (burst_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    write_q <= 1'b0;
    else if (load) write_q <= cfg_write;
  end

  lane_gen #(.LEN_W(LEN_W)) u_lane (
    .step   (step),
    .write  (write_q),
    .wide   (wide),
    .rem    (rem),
    .mem_we (mem_we),
    .mem_re (mem_re),
    .mem_be (mem_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       eot_flag <= 1'b0;
    else if (done)    eot_flag <= 1'b1;
    else if (eot_clr) eot_flag <= 1'b0;
  end

  assign irq = eot_flag & cfg_eot_ie;

endmodule

// File: rtl/burst_dreq_engine_chk.sv
module burst_dreq_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_int,
  input logic              step,
  input logic              done,
  input logic              last_beat,
  input logic              burst_end,
  input logic              busy,
  input logic              wide,
  input logic [LEN_W-1:0]  rem,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic [3:0]        mem_be,
  input logic              eot_flag,
  input logic              irq
);

  // R7
  strobe_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> req_int);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last_beat) |=> mem_addr == $past(mem_addr) + ADDR_W'(wide ? 4 : 2));

  // R4
  burst_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && burst_end && !last_beat) |=> (!req_int && busy));

  // R8
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !req_int && eot_flag));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> ($stable(rem) && $stable(mem_addr)));

  // R6
  read_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_be == (wide ? 4'hF : 4'h3)));

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> eot_flag);

endmodule

bind burst_dreq_engine burst_dreq_engine_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_int   (req_int),
  .step      (step),
  .done      (done),
  .last_beat (last_beat),
  .burst_end (burst_end),
  .busy      (busy),
  .wide      (wide),
  .rem       (rem),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_be    (mem_be),
  .eot_flag  (eot_flag),
  .irq       (irq)
);

// File: tb/test_burst_dreq_engine.sv
module test_burst_dreq_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_start = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic        cfg_write = 1'b0;
  logic [11:0] cfg_burst = '0;
  logic [15:0] cfg_len = '0;
  logic        cfg_wide = 1'b0;
  logic        cfg_req_hi = 1'b1;
  logic        cfg_ack_hi = 1'b1;
  logic        cfg_eot_ie = 1'b1;
  logic        eot_clr = 1'b0;
  logic        dma_ack = 1'b0;
  logic        dma_req, busy, mem_we, mem_re, eot_flag, irq;
  logic [15:0] mem_addr;
  logic [3:0]  mem_be;

  always #10 clk = ~clk;

  burst_dreq_engine i_burst_dreq_engine (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_addr(cfg_addr),
    .cfg_write(cfg_write), .cfg_burst(cfg_burst), .cfg_len(cfg_len),
    .cfg_wide(cfg_wide), .cfg_req_hi(cfg_req_hi), .cfg_ack_hi(cfg_ack_hi),
    .cfg_eot_ie(cfg_eot_ie), .eot_clr(eot_clr), .dma_ack(dma_ack),
    .dma_req(dma_req), .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_be(mem_be), .eot_flag(eot_flag), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  function automatic logic req_on();
    return cfg_req_hi ? dma_req : ~dma_req;
  endfunction

  task automatic set_ack(input bit on);
    dma_ack = cfg_ack_hi ? on : ~on;
  endtask

  typedef struct packed {
    logic        wide;
    logic        wr;
    logic [15:0] addr;
    logic [11:0] burst;
    logic [15:0] len;
    logic [7:0]  beats;
    logic [3:0]  bursts;
    logic [3:0]  be;
    logic [15:0] last;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 16'h0100, 12'd8,  16'd10, 8'd3, 4'd2, 4'b0011, 16'h0108},
    '{1'b0, 1'b1, 16'h0200, 12'd8,  16'd10, 8'd5, 4'd2, 4'b0011, 16'h0208},
    '{1'b0, 1'b1, 16'h0040, 12'd4,  16'd7,  8'd4, 4'd2, 4'b0001, 16'h0046},
    '{1'b1, 1'b0, 16'h0080, 12'd16, 16'd13, 8'd4, 4'd1, 4'b1111, 16'h008C},
    '{1'b1, 1'b1, 16'h0013, 12'd4,  16'd5,  8'd2, 4'd2, 4'b0001, 16'h0014},
    '{1'b1, 1'b1, 16'h0000, 12'd6,  16'd12, 8'd3, 4'd2, 4'b1111, 16'h0008},
    '{1'b0, 1'b0, 16'h0300, 12'd2,  16'd3,  8'd2, 4'd2, 4'b0011, 16'h0302}
  };

  // Starts at a negedge, returns at the negedge after completion.
  task automatic run_vec(input vec_t v, input bit ack_now);
    int beats = 0;
    int bursts = 0;
    int spins = 0;
    bit prev = 1'b0;
    logic [3:0]  lbe = '0;
    logic [15:0] laddr = '0;
    int bw;
    bw = v.wide ? 4 : 2;
    cfg_wide = v.wide; cfg_write = v.wr; cfg_addr = v.addr;
    cfg_burst = v.burst; cfg_len = v.len; cfg_start = 1'b1;
    set_ack(ack_now);
    @(negedge clk);
    cfg_start = 1'b0;
    // R2: request active one cycle after the start strobe
    chk(req_on() && busy, "R2", int'({req_on(), busy}), 3);
    while (busy && spins < 4000) begin
      if (req_on() && (cfg_ack_hi ? dma_ack : ~dma_ack)) begin
        beats++;
        if (!prev) bursts++;
        // R3: address advances by bus width
        if (beats > 1) chk(mem_addr == laddr + 16'(bw), "R3", int'(mem_addr), int'(laddr) + bw);
        // R7: strobe matches direction
        chk(mem_we == v.wr && mem_re == !v.wr, "R7", int'({mem_we, mem_re}), int'({v.wr, !v.wr}));
        lbe = mem_be; laddr = mem_addr;
      end else begin
        // R12: no strobe without a beat
        chk(!mem_we && !mem_re, "R12", int'({mem_we, mem_re}), 0);
      end
      prev = req_on();
      @(negedge clk);
      spins++;
    end
    // R5/R12: total beats
    chk(beats == int'(v.beats), "R5", beats, int'(v.beats));
    // R4: burst count
    chk(bursts == int'(v.bursts), "R4", bursts, int'(v.bursts));
    // R6: final lane mask
    chk(lbe == v.be, "R6", int'(lbe), int'(v.be));
    // R3: last beat address (aligned start)
    chk(laddr == v.last, "R3", int'(laddr), int'(v.last));
    // R8: end state
    chk(!req_on() && !busy && eot_flag, "R8", int'({req_on(), busy, eot_flag}), 1);
  endtask

  task automatic clear_eot();
    eot_clr = 1'b1;
    @(negedge clk);
    eot_clr = 1'b0;
    // R9: cleared flag and interrupt
    chk(!eot_flag && !irq, "R9", int'({eot_flag, irq}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(dma_req == 1'b0 && !busy && !eot_flag && !irq, "R1",
        int'({dma_req, busy, eot_flag, irq}), 0);

    for (int i = 0; i < NV; i++) begin
      run_vec(TBL[i], 1'b1);
      // R9: interrupt follows flag when enabled
      chk(irq == 1'b1, "R9", int'(irq), 1);
      clear_eot();
    end

    // R9: interrupt masked
    cfg_eot_ie = 1'b0;
    run_vec(TBL[0], 1'b1);
    chk(irq == 1'b0 && eot_flag, "R9", int'({irq, eot_flag}), 1);
    clear_eot();
    cfg_eot_ie = 1'b1;

    // R2: zero length ignored
    cfg_len = '0; cfg_start = 1'b1; set_ack(1'b1);
    @(negedge clk);
    cfg_start = 1'b0;
    @(negedge clk);
    chk(!busy && !req_on() && !eot_flag, "R2", int'({busy, req_on(), eot_flag}), 0);

    // R11: start while busy ignored; ack held off first
    cfg_wide = 1'b1; cfg_write = 1'b1; cfg_addr = 16'h0500;
    cfg_burst = 12'd8; cfg_len = 16'd8; cfg_start = 1'b1; set_ack(1'b0);
    @(negedge clk);
    cfg_start = 1'b0;
    repeat (2) @(negedge clk);
    // R12: no beat without acknowledge
    chk(req_on() && !mem_we && mem_addr == 16'h0500, "R12", int'(mem_addr), 16'h0500);
    cfg_addr = 16'h0400; cfg_len = 16'd40; cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    chk(busy && mem_addr == 16'h0500, "R11", int'(mem_addr), 16'h0500);
    begin
      int beats = 0;
      int spins = 0;
      set_ack(1'b1);
      while (busy && spins < 200) begin
        if (req_on()) beats++;
        @(negedge clk);
        spins++;
      end
      chk(beats == 2, "R11", beats, 2);
    end
    clear_eot();

    // R10: inverted pin levels
    cfg_req_hi = 1'b0; cfg_ack_hi = 1'b0; set_ack(1'b0);
    @(negedge clk);
    chk(dma_req == 1'b1, "R10", int'(dma_req), 1);
    run_vec(TBL[0], 1'b1);
    chk(dma_req == 1'b1, "R10", int'(dma_req), 1);
    clear_eot();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule